// File: doc/BRIEF.md
# DRAM Mode Register Update Sequencer

This controller-side block writes one mode register of a DDR3-class SDRAM. A client hands it a register select and a 16-bit value through a valid/ready handshake. The block holds the request until the memory is quiet: all banks closed, the row precharge time spent since the last precharge, no data burst running, and clock enable high. It then drives a single mode-register-set command on the command/address pins. After that it sends only NOP cycles until the programmable post-update delay has run out, and signals completion with a one-cycle pulse.

The block also owns the on-die termination (ODT) pin during the update. It keeps its own copy of the nominal-termination enable held in the termination-carrying register. If termination is on under the old setting or under the value being written, the block forces ODT low from the cycle after the request is taken until the delay expires. It delays the command until ODT has been low for a programmable guard interval. If termination is off on both sides, the client's ODT request passes straight through.

Top module: `mrs_sequencer`

## Requirements
- R1: `req_ready_o` is high only while no update is in progress. A request is taken on a cycle with both valid and ready high. Select and value are captured in that cycle, and later changes on `req_sel_i`/`req_val_i` do not alter the command driven.
- R2: The update command drives `{cs_n,ras_n,cas_n,we_n}` = 4'b0000, `ba_o` = captured select and `addr_o` = captured value bits [13:0], for exactly one cycle.
- R3: The command is withheld, with the request kept, while `banks_idle_i` is low, `burst_active_i` is high or `cke_i` is low. It is issued in the cycle after the first waiting cycle in which all clear.
- R4: A `pre_issue_i` pulse in cycle p blocks the command in every waiting cycle before p + `trp_cyc_i`. The command appears at the earliest one cycle after that.
- R5: Every cycle after the command and before the done cycle carries NOP: `{cs_n,ras_n,cas_n,we_n}` = 4'b0111.
- R6: `done_o` is high for one cycle, max(`tmod_cyc_i`,1) cycles after the command cycle. `req_ready_o` returns high in the following cycle.
- R7: When termination applies, `odt_o` is 0 from the cycle after acceptance up to the cycle before done. In the done cycle it follows `odt_req_i` again.
- R8: When termination applies, the command is issued only after `odt_o` has been low for at least `odtloff_cyc_i`+1 consecutive cycles immediately before it.
- R9: When termination applies to neither the old nor the new setting, `odt_o` equals `odt_req_i` in every cycle.
- R10: Termination applies when the held enable is set, or when the write targets register 1 and its value has any of bits 2, 6 or 9 set. The held enable resets to 0, is reloaded only by completed writes to register 1, and is unchanged by writes to other registers.
- R11: Outside the wait, command and delay phases the command pins drive deselect (`cs_n_o` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Update request valid |
| req_ready_o | output | 1 | Block can take a request |
| req_sel_i | input | BA_W | Mode register select |
| req_val_i | input | VAL_W | Register value |
| tmod_cyc_i | input | CNT_W | Post-update delay in cycles |
| odtloff_cyc_i | input | CNT_W | Guard base; ODT low for this plus one cycles |
| trp_cyc_i | input | CNT_W | Row precharge time in cycles |
| pre_issue_i | input | 1 | A precharge was issued this cycle |
| banks_idle_i | input | 1 | All banks precharged |
| burst_active_i | input | 1 | A data burst is running |
| cke_i | input | 1 | Clock enable is high |
| odt_req_i | input | 1 | Client ODT request |
| odt_o | output | 1 | ODT to memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address / register select |
| addr_o | output | ADDR_W | Address / register value |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default widths: 8-bit counters, a 3-bit select and a 14-bit address. It drives small runtime values: delay 0 to 4, guard base 0 to 3, and precharge time 2 to 5. These small values make each of the four wait sources (busy memory, precharge time, ODT guard, none) the one that sets the issue cycle in turn. Every combination of select, termination bits, blocking input, blocking length, precharge pulse and prior ODT level is swept. Old/new termination pairs therefore arise in all four pairings. Every cycle of each update is compared against arithmetically derived expectations.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ISSUE,
    ST_MOD,
    ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_DES = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/mrs_idle_track.sv
module mrs_idle_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_issue_i,
  input  logic [CNT_W-1:0] trp_cyc_i,
  input  logic             banks_idle_i,
  input  logic             burst_active_i,
  input  logic             cke_i,
  output logic             mem_ok_o
);

  logic [CNT_W-1:0] trp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trp_q <= '0;
    end else if (pre_issue_i) begin
      trp_q <= (trp_cyc_i == '0) ? '0 : trp_cyc_i - CNT_W'(1);
    end else if (trp_q != '0) begin
      trp_q <= trp_q - CNT_W'(1);
    end
  end

  assign mem_ok_o = banks_idle_i & ~burst_active_i & cke_i & ~pre_issue_i & (trp_q == '0);

  a_r4_trp_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_issue_i && trp_cyc_i > CNT_W'(1)) |=> !mem_ok_o);

endmodule

// File: rtl/mrs_odt_guard.sv
module mrs_odt_guard #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             odt_req_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] loff_i,
  input  logic             mrs_i,
  output logic             odt_o,
  output logic             guard_ok_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] low_q;

  assign odt_o = hold_i ? 1'b0 : odt_req_i;

  // consecutive low cycles before the current one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
    end else if (odt_o) begin
      low_q <= '0;
    end else if (low_q != CNT_MAX) begin
      low_q <= low_q + CNT_W'(1);
    end
  end

  // current cycle is low too, so low_q >= loff gives loff+1 lows before the command
  assign guard_ok_o = !hold_i || (low_q >= loff_i);

  a_r8_guard_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_i && hold_i) |-> (!odt_o && !$past(odt_o) && $past(low_q) >= $past(loff_i)));

endmodule

// File: rtl/mrs_mod_timer.sv
module mrs_mod_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] tmod_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= tmod_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // high in the last cycle before done
  assign expire_o = start_i ? (tmod_i <= CNT_W'(1)) : (cnt_q <= CNT_W'(2));

  a_r6_tmod_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && tmod_i > CNT_W'(2)) |=> !expire_o);

endmodule

// File: rtl/mrs_sequencer.sv
module mrs_sequencer
  import mrs_seq_pkg::*;
#(
  parameter int BA_W    = 3,
  parameter int ADDR_W  = 14,
  parameter int VAL_W   = 16,
  parameter int CNT_W   = 8,
  parameter int RTT_REG = 1,
  parameter logic [VAL_W-1:0] RTT_MASK = 16'h0244
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BA_W-1:0]   req_sel_i,
  input  logic [VAL_W-1:0]  req_val_i,
  input  logic [CNT_W-1:0]  tmod_cyc_i,
  input  logic [CNT_W-1:0]  odtloff_cyc_i,
  input  logic [CNT_W-1:0]  trp_cyc_i,
  input  logic              pre_issue_i,
  input  logic              banks_idle_i,
  input  logic              burst_active_i,
  input  logic              cke_i,
  input  logic              odt_req_i,
  output logic              odt_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam logic [BA_W-1:0] RTT_SEL = BA_W'(RTT_REG);

  seq_st_e          st_q, st_d;
  logic [BA_W-1:0]  sel_q;
  logic [VAL_W-1:0] val_q;
  logic             rtt_q;
  logic             is_rtt_reg, new_en, rule, hold;
  logic             mem_ok, guard_ok, expire;
  cmd_pins_t        cmd;

  assign is_rtt_reg = (sel_q == RTT_SEL);
  assign new_en     = is_rtt_reg ? |(val_q & RTT_MASK) : rtt_q;
  assign rule       = rtt_q | new_en;
  assign hold       = rule && (st_q == ST_WAIT || st_q == ST_ISSUE || st_q == ST_MOD);

  mrs_idle_track #(.CNT_W(CNT_W)) u_idle (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pre_issue_i    (pre_issue_i),
    .trp_cyc_i      (trp_cyc_i),
    .banks_idle_i   (banks_idle_i),
    .burst_active_i (burst_active_i),
    .cke_i          (cke_i),
    .mem_ok_o       (mem_ok)
  );

  mrs_odt_guard #(.CNT_W(CNT_W)) u_odt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .odt_req_i  (odt_req_i),
    .hold_i     (hold),
    .loff_i     (odtloff_cyc_i),
    .mrs_i      (st_q == ST_ISSUE),
    .odt_o      (odt_o),
    .guard_ok_o (guard_ok)
  );

  mrs_mod_timer #(.CNT_W(CNT_W)) u_mod (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (st_q == ST_ISSUE),
    .tmod_i   (tmod_cyc_i),
    .expire_o (expire)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = ST_WAIT;
      ST_WAIT:  if (mem_ok && guard_ok) st_d = ST_ISSUE;
      ST_ISSUE: st_d = expire ? ST_DONE : ST_MOD;
      ST_MOD:   if (expire) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      val_q <= '0;
      rtt_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid_i) begin
        sel_q <= req_sel_i;
        val_q <= req_val_i;
      end
      // old setting must stay visible until the delay has run out
      if (st_q == ST_DONE && is_rtt_reg) rtt_q <= new_en;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_ISSUE: cmd = CMD_MRS;
      ST_MOD:   cmd = CMD_NOP;
      default:  cmd = CMD_DES;
    endcase
  end

  assign cs_n_o      = cmd.cs_n;
  assign ras_n_o     = cmd.ras_n;
  assign cas_n_o     = cmd.cas_n;
  assign we_n_o      = cmd.we_n;
  assign ba_o        = (st_q == ST_ISSUE) ? sel_q : '0;
  assign addr_o      = (st_q == ST_ISSUE) ? val_q[ADDR_W-1:0] : '0;
  assign req_ready_o = (st_q == ST_IDLE);
  assign done_o      = (st_q == ST_DONE);

  a_r3_idle_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o && !cas_n_o && !we_n_o) |->
      $past(banks_idle_i && !burst_active_i && cke_i));

  a_r2_single_mrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o) |=> !(!cs_n_o && !ras_n_o));

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  a_r11_idle_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_n_o);

endmodule

// File: tb/tb_mrs_sequencer.sv
module tb_mrs_sequencer;

  localparam int BA_W = 3, ADDR_W = 14, VAL_W = 16, CNT_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_ni;
  logic              req_valid_i, req_ready_o;
  logic [BA_W-1:0]   req_sel_i;
  logic [VAL_W-1:0]  req_val_i;
  logic [CNT_W-1:0]  tmod_cyc_i, odtloff_cyc_i, trp_cyc_i;
  logic              pre_issue_i, banks_idle_i, burst_active_i, cke_i;
  logic              odt_req_i, odt_o;
  logic              cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [BA_W-1:0]   ba_o;
  logic [ADDR_W-1:0] addr_o;

  mrs_sequencer dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_sel_i(req_sel_i), .req_val_i(req_val_i),
    .tmod_cyc_i(tmod_cyc_i), .odtloff_cyc_i(odtloff_cyc_i), .trp_cyc_i(trp_cyc_i),
    .pre_issue_i(pre_issue_i), .banks_idle_i(banks_idle_i),
    .burst_active_i(burst_active_i), .cke_i(cke_i),
    .odt_req_i(odt_req_i), .odt_o(odt_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .done_o(done_o)
  );

  int vecs = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic sh = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  task automatic run_tx(int tm, int lo, int sel, int rv, int blk, int bb, int pl, int op);
    logic [15:0] val;
    logic new_en, need;
    int t, c, i_cyc, d_cyc;
    string itag, otag;
    val = (16'h3A5C ^ {8'(tm * 17), 8'(lo * 29 + sel)}) & ~16'h0244;
    if (rv != 0) val |= (lo % 3 == 0) ? 16'h0004 : (lo % 3 == 1) ? 16'h0040 : 16'h0200;
    new_en = (sel == 1) ? |(val & 16'h0244) : sh;
    need   = sh | new_en;
    t      = lo + 2;
    // idle gap
    for (int g = 0; g < 6; g++) begin
      @(negedge clk);
      req_valid_i = 1'b0; pre_issue_i = 1'b0;
      banks_idle_i = 1'b1; burst_active_i = 1'b0; cke_i = 1'b1;
      tmod_cyc_i = CNT_W'(tm); odtloff_cyc_i = CNT_W'(lo); trp_cyc_i = CNT_W'(t);
      odt_req_i = (op != 0);
      #1;
      chk("R1", req_ready_o, 1);
      chk("R11", pins(), 4'hF);
      chk("R9", odt_o, odt_req_i);
      chk("R6", done_o, 0);
    end
    c = 1;
    if (pl != 0 && t > c) c = t;
    if (bb + 1 > c) c = bb + 1;
    if (need && op != 0 && lo + 1 > c) c = lo + 1;
    if (need && op != 0 && lo + 1 == c && c > 1) itag = "R8";
    else if (pl != 0 && t == c) itag = "R4";
    else itag = "R3";
    i_cyc = c + 1;
    d_cyc = i_cyc + ((tm < 1) ? 1 : tm);
    otag = need ? ((sh && !new_en) ? "R10" : "R7") : "R9";
    for (int k = 0; k <= d_cyc + 1; k++) begin
      logic blocked, hold;
      @(negedge clk);
      blocked        = (k <= bb);
      req_valid_i    = (k == 0);
      req_sel_i      = (k == 0) ? BA_W'(sel) : ~BA_W'(sel);
      req_val_i      = (k == 0) ? val : ~val;
      pre_issue_i    = (pl != 0) && (k == 0);
      banks_idle_i   = !(blocked && blk == 0);
      burst_active_i = blocked && blk == 1;
      cke_i          = !(blocked && blk == 2);
      odt_req_i      = (k == 0) ? (op != 0) : 1'b1;
      #1;
      chk("R1", req_ready_o, (k == 0 || k == d_cyc + 1));
      if (k == i_cyc) begin
        chk(itag, pins(), 4'h0);
        chk("R2", ba_o, BA_W'(sel));
        chk("R1", addr_o, val[ADDR_W-1:0]);
      end else if (k > i_cyc && k < d_cyc) chk("R5", pins(), 4'h7);
      else if (k >= 1 && k < i_cyc) chk("R3", pins(), 4'hF);
      else chk("R11", pins(), 4'hF);
      chk("R6", done_o, (k == d_cyc));
      hold = need && k >= 1 && k < d_cyc;
      chk(otag, odt_o, hold ? 1'b0 : odt_req_i);
    end
    if (sel == 1) sh = new_en;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    req_valid_i = 1'b0; req_sel_i = '0; req_val_i = '0;
    tmod_cyc_i = CNT_W'(2); odtloff_cyc_i = '0; trp_cyc_i = '0;
    pre_issue_i = 1'b0; banks_idle_i = 1'b1; burst_active_i = 1'b0; cke_i = 1'b1;
    odt_req_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1", req_ready_o, 1);
    chk("R11", pins(), 4'hF);
    chk("R6", done_o, 0);
    chk("R10", odt_o, 1);
    for (int tm = 0; tm <= 4; tm++)
      for (int lo = 0; lo <= 3; lo++)
        for (int sel = 0; sel <= 2; sel++)
          for (int rv = 0; rv <= 1; rv++)
            for (int blk = 0; blk <= 2; blk++)
              for (int bb = 0; bb <= 2; bb += 2)
                for (int pl = 0; pl <= 1; pl++)
                  for (int op = 0; op <= 1; op++)
                    run_tx(tm, lo, sel, rv, blk, bb, pl, op);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule